// File: doc/BRIEF.md
# Release-Triggered Pushbutton Pulse Generator

This block takes the raw level of a mechanical pushbutton that idles high through a pull-up and reads low while its contacts are closed, and turns each complete press-and-release into a single pulse. The pulse is one system clock wide and aligned to that clock. Contact bounce shows up as an unpredictable run of high/low swings on both press and release, and the block absorbs it.

The raw level first passes through a two-stage flip-flop synchronizer. Every low-to-high transition of the synchronized level reloads a down-counter to a configurable number of cycles. When that counter runs out without being reloaded, a pulse is emitted, provided the synchronized level is still high at that moment. A release is therefore recognised only once the button has stayed open for longer than the configured quiet time. The quiet time must be longer than the spacing between successive bounce edges.

Top module: `btn_release_pulse`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `pulse_o` is 0. A button that stays high (released) through and after reset produces no pulse.
- R2: `pulse_o` is never high on two consecutive clock cycles.
- R3: When the raw input last rises in the cycle ending at rising clock edge n and then stays high, `pulse_o` is high in exactly the cycle that follows edge n + QUIET_CYCLES + 2. This accounts for two synchronizer stages, one edge register and the reloaded count.
- R4: Every rising edge of the synchronized input reloads the timer to QUIET_CYCLES. A burst of bounces whose rising edges are spaced closer than QUIET_CYCLES and which ends high yields exactly one pulse, timed from the last rise.
- R5: If the synchronized input is low when the timer runs out, no pulse is produced. A bouncing press that ends with the button held low yields no pulse.
- R6: Asserting `rst` while the timer is counting cancels the pending pulse. The synchronizer is cleared to the idle-high level, so no pulse follows after reset is released.
- R7: The counter never holds a value above QUIET_CYCLES.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_n_i | input | 1 | Raw pushbutton level, low while pressed, asynchronous |
| pulse_o | output | 1 | Registered one-cycle pulse per completed release |

## Verification
The bench drives random bounce bursts on both press and release, with segments shorter than the quiet time. It expects no pulse after a press and exactly one pulse after each release, landing on the cycle computed from the last rise. A design that counted from the first release edge would fire early and miss the cycle check. A design that did not reload on each rise would fire several times per release. A design that ignored the level at expiry would fire after a bouncing press. Reset is also asserted in the middle of a countdown, and a design that left the synchronizer at zero or kept the count would emit a stray pulse once reset is released.

// File: rtl/btn_pkg.sv
package btn_pkg;
  // Width needed to hold values 0..max_val.
  function automatic int unsigned cnt_width(input int unsigned max_val);
    int unsigned w;
    w = 1;
    while ((1 << w) <= max_val) w++;
    return w;
  endfunction
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic level_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;            // idle (released) level
    else     chain_q <= {chain_q[STAGES-2:0], raw_i};
  end

  assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/btn_rise.sv
module btn_rise (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/btn_quiet_timer.sv
module btn_quiet_timer
  import btn_pkg::*;
#(
  parameter int unsigned QUIET_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic reload_i,
  output logic expire_o
);
  localparam int unsigned CW = cnt_width(QUIET_CYCLES);
  localparam logic [CW-1:0] LOAD = CW'(QUIET_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (reload_i)       cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  // last counting cycle, not interrupted by a new rise
  assign expire_o = (cnt_q == CW'(1)) && !reload_i;

  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    reload_i |=> cnt_q == LOAD);
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LOAD);
endmodule

// File: rtl/btn_release_pulse.sv
module btn_release_pulse #(
  parameter int unsigned QUIET_CYCLES = 16,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_n_i,
  output logic pulse_o
);
  logic level, rise, expire, pulse_q;

  btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw_i(btn_n_i), .level_o(level));

  btn_rise u_rise (
    .clk(clk), .rst(rst), .level_i(level), .rise_o(rise));

  btn_quiet_timer #(.QUIET_CYCLES(QUIET_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .reload_i(rise), .expire_o(expire));

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= expire & level;
  end

  assign pulse_o = pulse_q;

  p_one_wide_r2: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
  p_level_gate_r5: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> $past(level));
  p_quiet_after_rst_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pulse_o);
  p_cancel_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !expire);
endmodule

// File: tb/tb_btn_release_pulse.sv
module tb_btn_release_pulse;
  localparam int unsigned D = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_n = 1'b1;
  logic pulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int npulse = 0;
  int last_pulse_cyc = -1;
  int last_rise_cyc = 0;
  logic prev_pulse = 1'b0;

  btn_release_pulse #(.QUIET_CYCLES(D)) dut (
    .clk(clk), .rst(rst), .btn_n_i(btn_n), .pulse_o(pulse));

  always #4 clk = ~clk;   // 125 MHz

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int expect_cyc(input int rise_c);
    return rise_c + D + 3;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (pulse) begin
      npulse++;
      last_pulse_cyc = cyc;
      if (prev_pulse) chk(1'b0, "R2 width", 2, 1);
    end
    prev_pulse = pulse;
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_btn(input logic v);
    if (v && !btn_n) last_rise_cyc = cyc;
    btn_n = v;
  endtask

  // bounce burst, every segment shorter than D, ending at final_v
  task automatic bounce(input logic final_v);
    int unsigned n;
    n = 3 + ($urandom % 6);
    for (int i = 0; i < int'(n); i++) begin
      set_btn((i % 2 == 0) ? final_v : ~final_v);
      step(1 + ($urandom % 6));
    end
    set_btn(final_v);
  endtask

  initial begin
    int base;
    void'($urandom(32'd1234));
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      step(1);
      chk(pulse == 1'b0, "R1 in reset", pulse, 0);
    end
    rst = 1'b0;
    step(1);
    chk(pulse == 1'b0, "R1 after reset", pulse, 0);
    step(3 * D);
    chk(npulse == 0, "R1 idle high", npulse, 0);

    // directed clean press and release
    set_btn(1'b0); step(3 * D);
    chk(npulse == 0, "R5 clean press", npulse, 0);
    set_btn(1'b1); base = npulse; step(3 * D);
    chk(npulse == base + 1, "R3 clean release count", npulse - base, 1);
    chk(last_pulse_cyc == expect_cyc(last_rise_cyc), "R3 latency",
        last_pulse_cyc, expect_cyc(last_rise_cyc));

    // random bouncing rounds
    for (int r = 0; r < 10; r++) begin
      base = npulse;
      bounce(1'b0); step(3 * D);
      chk(npulse == base, "R5 bouncing press", npulse - base, 0);
      bounce(1'b1); step(3 * D);
      chk(npulse == base + 1, "R4 one pulse per release", npulse - base, 1);
      chk(last_pulse_cyc == expect_cyc(last_rise_cyc), "R4 timed from last rise",
          last_pulse_cyc, expect_cyc(last_rise_cyc));
    end

    // reset in the middle of a countdown
    set_btn(1'b0); step(3 * D);
    base = npulse;
    set_btn(1'b1); step(D / 2);
    rst = 1'b1; step(3);
    rst = 1'b0; step(3 * D);
    chk(npulse == base, "R6 reset cancels", npulse - base, 0);

    // a lone one-cycle glitch while held low
    set_btn(1'b0); step(3 * D);
    base = npulse;
    set_btn(1'b1); step(1); set_btn(1'b0); step(3 * D);
    chk(npulse == base, "R5 glitch during hold", npulse - base, 0);
    set_btn(1'b1); step(3 * D);
    chk(npulse == base + 1, "R3 release after glitch", npulse - base, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule